// File: doc/BRIEF.md
# CAN FD Dual-Rate Bit Timing Generator

This block sits beside the bit-level framing logic of a CAN FD controller and tells it when to sample the bus and when a bit ends. It divides the system clock by a prescaler into time quanta. Each bit is split into two segments: a number of quanta before the sample point and a number after it. Two complete sets of timing values are held, one for the arbitration (nominal) phase and one for the fast data phase. A one-cycle sample strobe marks the sample point, a one-cycle bit-end strobe marks the boundary, and a flag tells which timing set is active.

The framing logic drives a marker pulse during the bit-rate-switch bit and another during the CRC delimiter bit. The switch to fast timing does not wait for a bit boundary. It happens at the sample point of the marked switch bit, so the rest of that bit is already timed with the data-phase values. Timing returns to nominal values at the sample point of the CRC delimiter. While the bus is idle, a recessive-to-dominant edge restarts the counters at the start of a bit (hard sync). The timing values and the two enables are captured only while the configuration input is held high.

Top module: `canfd_bittime`

## Requirements
- R1: With nominal timing, consecutive bit-end strobes are prescaler × (quanta before + quanta after) system clocks apart. For example, prescaler 2 with 32+8 quanta gives 80 clocks (500 kbit/s at 40 MHz).
- R2: Within a bit, the sample strobe comes prescaler × (quanta before) clocks after the bit-end strobe that opened the bit, and the next bit-end strobe comes prescaler × (quanta after) clocks after the sample strobe.
- R3: While the phase flag is 1, bits are timed with the data-phase prescaler and quanta. For example, prescaler 1 with 15+5 quanta gives 20 clocks per bit (2 Mbit/s at 40 MHz).
- R4: A pulse on `brs_mark` arms a switch that acts at the next sample point. At that sample strobe, `data_phase` rises in the same cycle. The remainder of that bit lasts data prescaler × data quanta-after clocks.
- R5: The switch happens only when both `fd_enable` and `rate_sw_enable` were captured as 1. Otherwise `data_phase` stays 0 and every bit uses nominal timing.
- R6: A pulse on `crcdel_mark` arms a return that acts at the next sample point. At that sample strobe, `data_phase` falls in the same cycle. The remainder of that bit lasts nominal prescaler × nominal quanta-after clocks.
- R7: When `hsync_edge` is seen with `bus_idle` high and the block running, the counters restart at bit start. The next sample strobe then comes prescaler × (quanta before) clocks after the capturing clock edge, and `data_phase` returns to 0. With `bus_idle` low, the edge has no effect.
- R8: Timing values and enables are captured only while `cfg_mode` is 1. Changes on those inputs while running do not alter the bit timing.
- R9: Each strobe is exactly one clock wide. The two strobes never coincide. While `cfg_mode` is 1, no strobe is produced and `data_phase` is 0.
- R10: After reset, `sample_stb`, `bit_end_stb` and `data_phase` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration hold: captures timing values, stops the counters |
| nom_presc | input | PRESC_W | Nominal prescaler (clocks per quantum) |
| nom_tq_pre | input | TQ_W | Nominal quanta before the sample point |
| nom_tq_post | input | TQ_W | Nominal quanta after the sample point |
| dat_presc | input | PRESC_W | Data-phase prescaler |
| dat_tq_pre | input | TQ_W | Data-phase quanta before the sample point |
| dat_tq_post | input | TQ_W | Data-phase quanta after the sample point |
| fd_enable | input | 1 | FD operation enable (captured in configuration) |
| rate_sw_enable | input | 1 | Bit rate switching enable (captured in configuration) |
| bus_idle | input | 1 | Framing logic reports an idle bus |
| hsync_edge | input | 1 | Recessive-to-dominant edge detected on the bus |
| brs_mark | input | 1 | Pulse during the rate-switch bit, before its sample point |
| crcdel_mark | input | 1 | Pulse during the CRC delimiter bit, before its sample point |
| sample_stb | output | 1 | One-clock sample point strobe |
| bit_end_stb | output | 1 | One-clock bit boundary strobe |
| data_phase | output | 1 | 1 while data-phase timing is active |

## Verification
The hardest case to reach is the switch bit itself. Its first segment must be nominal and its second segment data-phase, and both need to be seen against independently computed clock counts. The stimulus waits for a bit-end strobe and then raises the switch marker in the same cycle. The following sample strobe is therefore that bit's sample point. The bench then times the split bit, a full fast bit, and the split CRC delimiter bit on the way back. This sequence is repeated for several random sets of nominal and data-phase values. Hard sync is hit at the same known point in a bit, once with the bus idle and once without, so the one-clock difference in the next sample time shows whether the edge was taken.

// File: rtl/canfd_bt_pkg.sv
package canfd_bt_pkg;
  typedef enum logic {SEG_PRE = 1'b0, SEG_POST = 1'b1} seg_e;
  localparam int SET_NOM = 0;
  localparam int SET_DAT = 1;
  localparam int NUM_SETS = 2;
endpackage

// File: rtl/canfd_bt_params.sv
module canfd_bt_params #(
  parameter int PW = 6,
  parameter int QW = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic capture,
  input  logic [canfd_bt_pkg::NUM_SETS-1:0][PW-1:0] presc_in,
  input  logic [canfd_bt_pkg::NUM_SETS-1:0][QW-1:0] pre_in,
  input  logic [canfd_bt_pkg::NUM_SETS-1:0][QW-1:0] post_in,
  input  logic fd_in,
  input  logic brs_in,
  output logic [canfd_bt_pkg::NUM_SETS-1:0][PW-1:0] presc_q,
  output logic [canfd_bt_pkg::NUM_SETS-1:0][QW-1:0] pre_q,
  output logic [canfd_bt_pkg::NUM_SETS-1:0][QW-1:0] post_q,
  output logic fd_q,
  output logic brs_q
);
  // one shadow set per timing phase; zero values are clamped to one
  for (genvar s = 0; s < canfd_bt_pkg::NUM_SETS; s++) begin : g_set
    logic [PW-1:0] p_r;
    logic [QW-1:0] a_r;
    logic [QW-1:0] b_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        p_r <= PW'(1);
        a_r <= QW'(1);
        b_r <= QW'(1);
      end else if (capture) begin
        p_r <= (presc_in[s] == '0) ? PW'(1) : presc_in[s];
        a_r <= (pre_in[s]   == '0) ? QW'(1) : pre_in[s];
        b_r <= (post_in[s]  == '0) ? QW'(1) : post_in[s];
      end
    end
    assign presc_q[s] = p_r;
    assign pre_q[s]   = a_r;
    assign post_q[s]  = b_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fd_q  <= 1'b0;
      brs_q <= 1'b0;
    end else if (capture) begin
      fd_q  <= fd_in;
      brs_q <= brs_in;
    end
  end
endmodule

// File: rtl/canfd_bt_quanta.sv
module canfd_bt_quanta #(
  parameter int PW = 6,
  parameter int QW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          restart,
  input  logic [PW-1:0] presc,
  input  logic [QW-1:0] pre,
  input  logic [QW-1:0] post,
  output logic          pre_done,
  output logic          post_done
);
  import canfd_bt_pkg::*;

  logic [PW-1:0] pcnt;
  logic [QW-1:0] qcnt;
  seg_e          seg;
  logic          qtick;
  logic          seg_last;
  logic          active;

  assign active   = run && !restart;
  assign qtick    = (pcnt >= presc - PW'(1));
  assign seg_last = (seg == SEG_PRE) ? (qcnt >= pre - QW'(1))
                                     : (qcnt >= post - QW'(1));
  assign pre_done  = active && qtick && seg_last && (seg == SEG_PRE);
  assign post_done = active && qtick && seg_last && (seg == SEG_POST);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pcnt <= '0;
      qcnt <= '0;
      seg  <= SEG_PRE;
    end else if (qtick) begin
      pcnt <= '0;
      if (seg_last) begin
        qcnt <= '0;
        seg  <= (seg == SEG_PRE) ? SEG_POST : SEG_PRE;
      end else begin
        qcnt <= qcnt + QW'(1);
      end
    end else begin
      pcnt <= pcnt + PW'(1);
    end
  end
endmodule

// File: rtl/canfd_bt_phase.sv
module canfd_bt_phase (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic restart,
  input  logic switch_ok,
  input  logic brs_mark,
  input  logic crcdel_mark,
  input  logic sample_now,
  output logic data_phase
);
  logic brs_arm;
  logic crc_arm;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      data_phase <= 1'b0;
      brs_arm    <= 1'b0;
      crc_arm    <= 1'b0;
    end else if (sample_now) begin
      brs_arm <= 1'b0;
      crc_arm <= 1'b0;
      if ((brs_arm || brs_mark) && switch_ok)
        data_phase <= 1'b1;
      else if (crc_arm || crcdel_mark)
        data_phase <= 1'b0;
    end else begin
      if (brs_mark)    brs_arm <= 1'b1;
      if (crcdel_mark) crc_arm <= 1'b1;
    end
  end
endmodule

// File: rtl/canfd_bittime.sv
module canfd_bittime #(
  parameter int PRESC_W = 6,
  parameter int TQ_W    = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_mode,
  input  logic [PRESC_W-1:0] nom_presc,
  input  logic [TQ_W-1:0]    nom_tq_pre,
  input  logic [TQ_W-1:0]    nom_tq_post,
  input  logic [PRESC_W-1:0] dat_presc,
  input  logic [TQ_W-1:0]    dat_tq_pre,
  input  logic [TQ_W-1:0]    dat_tq_post,
  input  logic               fd_enable,
  input  logic               rate_sw_enable,
  input  logic               bus_idle,
  input  logic               hsync_edge,
  input  logic               brs_mark,
  input  logic               crcdel_mark,
  output logic               sample_stb,
  output logic               bit_end_stb,
  output logic               data_phase
);
  import canfd_bt_pkg::*;

  logic [NUM_SETS-1:0][PRESC_W-1:0] presc_in, presc_q;
  logic [NUM_SETS-1:0][TQ_W-1:0]    pre_in, pre_q, post_in, post_q;
  logic fd_lat, brs_lat;
  logic run, restart;
  logic pre_done, post_done;
  logic [PRESC_W-1:0] cur_presc;
  logic [TQ_W-1:0]    cur_pre, cur_post;

  assign presc_in[SET_NOM] = nom_presc;
  assign presc_in[SET_DAT] = dat_presc;
  assign pre_in[SET_NOM]   = nom_tq_pre;
  assign pre_in[SET_DAT]   = dat_tq_pre;
  assign post_in[SET_NOM]  = nom_tq_post;
  assign post_in[SET_DAT]  = dat_tq_post;

  assign run     = !cfg_mode;
  assign restart = run && bus_idle && hsync_edge;

  canfd_bt_params #(.PW(PRESC_W), .QW(TQ_W)) u_params (
    .clk(clk), .rst(rst), .capture(cfg_mode),
    .presc_in(presc_in), .pre_in(pre_in), .post_in(post_in),
    .fd_in(fd_enable), .brs_in(rate_sw_enable),
    .presc_q(presc_q), .pre_q(pre_q), .post_q(post_q),
    .fd_q(fd_lat), .brs_q(brs_lat)
  );

  // active set follows the registered phase flag, so the segment after a
  // switching sample point already runs on the new values
  always_comb begin
    if (data_phase) begin
      cur_presc = presc_q[SET_DAT];
      cur_pre   = pre_q[SET_DAT];
      cur_post  = post_q[SET_DAT];
    end else begin
      cur_presc = presc_q[SET_NOM];
      cur_pre   = pre_q[SET_NOM];
      cur_post  = post_q[SET_NOM];
    end
  end

  canfd_bt_quanta #(.PW(PRESC_W), .QW(TQ_W)) u_quanta (
    .clk(clk), .rst(rst), .run(run), .restart(restart),
    .presc(cur_presc), .pre(cur_pre), .post(cur_post),
    .pre_done(pre_done), .post_done(post_done)
  );

  canfd_bt_phase u_phase (
    .clk(clk), .rst(rst), .run(run), .restart(restart),
    .switch_ok(fd_lat && brs_lat),
    .brs_mark(brs_mark), .crcdel_mark(crcdel_mark),
    .sample_now(pre_done),
    .data_phase(data_phase)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sample_stb  <= 1'b0;
      bit_end_stb <= 1'b0;
    end else begin
      sample_stb  <= pre_done;
      bit_end_stb <= post_done;
    end
  end
endmodule

// File: rtl/canfd_bittime_chk.sv
module canfd_bittime_chk (
  input logic clk,
  input logic rst,
  input logic cfg_mode,
  input logic bus_idle,
  input logic hsync_edge,
  input logic fd_lat,
  input logic brs_lat,
  input logic sample_stb,
  input logic bit_end_stb,
  input logic data_phase
);
  assert_sample_one_clk_R9: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);
  assert_end_one_clk_R9: assert property (@(posedge clk) disable iff (rst)
    bit_end_stb |=> !bit_end_stb);
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (rst)
    !(sample_stb && bit_end_stb));
  assert_quiet_in_cfg_R9: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |=> (!sample_stb && !bit_end_stb && !data_phase));
  assert_phase_moves_at_sample_R4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(data_phase) && data_phase) |-> sample_stb);
  assert_phase_enable_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(data_phase) |-> (fd_lat && brs_lat));
  assert_hard_sync_R7: assert property (@(posedge clk) disable iff (rst)
    (!cfg_mode && bus_idle && hsync_edge) |=>
      (!sample_stb && !bit_end_stb && !data_phase));
endmodule

bind canfd_bittime canfd_bittime_chk u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .bus_idle(bus_idle),
  .hsync_edge(hsync_edge), .fd_lat(fd_lat), .brs_lat(brs_lat),
  .sample_stb(sample_stb), .bit_end_stb(bit_end_stb), .data_phase(data_phase)
);

// File: tb/canfd_bittime_test.sv
module canfd_bittime_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 6;
  localparam int QW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode = 1'b0;
  logic [PW-1:0] nom_presc = '0, dat_presc = '0;
  logic [QW-1:0] nom_tq_pre = '0, nom_tq_post = '0, dat_tq_pre = '0, dat_tq_post = '0;
  logic fd_enable = 1'b0, rate_sw_enable = 1'b0;
  logic bus_idle = 1'b0, hsync_edge = 1'b0, brs_mark = 1'b0, crcdel_mark = 1'b0;
  logic sample_stb, bit_end_stb, data_phase;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int np, npr, npo, dp, dpr, dpo;

  canfd_bittime #(.PRESC_W(PW), .TQ_W(QW)) uut (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode),
    .nom_presc(nom_presc), .nom_tq_pre(nom_tq_pre), .nom_tq_post(nom_tq_post),
    .dat_presc(dat_presc), .dat_tq_pre(dat_tq_pre), .dat_tq_post(dat_tq_post),
    .fd_enable(fd_enable), .rate_sw_enable(rate_sw_enable),
    .bus_idle(bus_idle), .hsync_edge(hsync_edge),
    .brs_mark(brs_mark), .crcdel_mark(crcdel_mark),
    .sample_stb(sample_stb), .bit_end_stb(bit_end_stb), .data_phase(data_phase)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int seg_clocks(input int p, input int q);
    return p * q;
  endfunction

  function automatic int bit_clocks(input int p, input int a, input int b);
    return p * (a + b);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // waits for the next strobe, observed at falling edges
  task automatic next_stb(input bit want_end, output int c);
    c = -1;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if ((want_end && bit_end_stb) || (!want_end && sample_stb)) begin
        c = cyc;
        return;
      end
    end
    chk("watchdog strobe wait", 0, 1);
  endtask

  task automatic configure(input bit fd, input bit brs);
    @(negedge clk);
    cfg_mode = 1'b1;
    nom_presc = PW'(np); nom_tq_pre = QW'(npr); nom_tq_post = QW'(npo);
    dat_presc = PW'(dp); dat_tq_pre = QW'(dpr); dat_tq_post = QW'(dpo);
    fd_enable = fd; rate_sw_enable = brs;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 quiet in config", {29'd0, sample_stb, bit_end_stb, data_phase}, 0);
    end
    cfg_mode = 1'b0;
  endtask

  task automatic nominal_bit(input string tag);
    int e1, s, e2;
    next_stb(1'b1, e1);
    next_stb(1'b0, s);
    next_stb(1'b1, e2);
    chk({tag, " R1 bit length"}, e2 - e1, bit_clocks(np, npr, npo));
    chk({tag, " R2 to sample"}, s - e1, seg_clocks(np, npr));
    chk({tag, " R2 after sample"}, e2 - s, seg_clocks(np, npo));
  endtask

  task automatic switch_sequence();
    int e, s, c;
    next_stb(1'b1, e);
    brs_mark = 1'b1;
    @(negedge clk);
    brs_mark = 1'b0;
    next_stb(1'b0, s);
    chk("R4 switch bit sample", s - e, seg_clocks(np, npr));
    chk("R4 flag with sample", int'(data_phase), 1);
    next_stb(1'b1, c);
    chk("R4 switch bit tail", c - s, seg_clocks(dp, dpo));
    e = c;
    next_stb(1'b0, s);
    chk("R3 data pre", s - e, seg_clocks(dp, dpr));
    next_stb(1'b1, c);
    chk("R3 data post", c - s, seg_clocks(dp, dpo));
    e = c;
    crcdel_mark = 1'b1;
    @(negedge clk);
    crcdel_mark = 1'b0;
    next_stb(1'b0, s);
    chk("R6 delimiter sample", s - e, seg_clocks(dp, dpr));
    chk("R6 flag with sample", int'(data_phase), 0);
    next_stb(1'b1, c);
    chk("R6 delimiter tail", c - s, seg_clocks(np, npo));
  endtask

  initial begin
    int seed;
    int e, s;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", {29'd0, sample_stb, bit_end_stb, data_phase}, 0);
    rst = 1'b0;

    // directed: 80-clock nominal, 20-clock data bits
    np = 2; npr = 32; npo = 8; dp = 1; dpr = 15; dpo = 5;
    configure(1'b1, 1'b1);
    nominal_bit("dir");
    next_stb(1'b0, s);
    @(negedge clk);
    chk("R9 sample width", int'(sample_stb), 0);
    switch_sequence();
    nominal_bit("after");

    // R8: running changes are ignored
    nom_presc = PW'(3); nom_tq_pre = QW'(5); nom_tq_post = QW'(2);
    nominal_bit("R8 ignore");

    // R7: hard sync taken while idle, one clock later than undisturbed
    next_stb(1'b1, e);
    bus_idle = 1'b1; hsync_edge = 1'b1;
    @(negedge clk);
    hsync_edge = 1'b0; bus_idle = 1'b0;
    chk("R7 no strobe at sync", {30'd0, sample_stb, bit_end_stb}, 0);
    next_stb(1'b0, s);
    chk("R7 sync to sample", s - e, seg_clocks(np, npr) + 1);
    next_stb(1'b1, e);
    hsync_edge = 1'b1;
    @(negedge clk);
    hsync_edge = 1'b0;
    next_stb(1'b0, s);
    chk("R7 ignored when busy", s - e, seg_clocks(np, npr));

    // R5: rate switching disabled keeps nominal timing
    np = 1; npr = 6; npo = 3; dp = 1; dpr = 2; dpo = 2;
    configure(1'b1, 1'b0);
    next_stb(1'b1, e);
    brs_mark = 1'b1;
    @(negedge clk);
    brs_mark = 1'b0;
    next_stb(1'b0, s);
    chk("R5 flag stays low", int'(data_phase), 0);
    next_stb(1'b1, e);
    chk("R5 nominal tail", e - s, seg_clocks(np, npo));
    configure(1'b0, 1'b1);
    next_stb(1'b1, e);
    brs_mark = 1'b1;
    @(negedge clk);
    brs_mark = 1'b0;
    next_stb(1'b0, s);
    chk("R5 fd off flag low", int'(data_phase), 0);

    // random timing sets
    for (int it = 0; it < 8; it++) begin
      np  = $urandom_range(1, 3); npr = $urandom_range(2, 10); npo = $urandom_range(2, 6);
      dp  = $urandom_range(1, 3); dpr = $urandom_range(2, 8);  dpo = $urandom_range(2, 6);
      configure(1'b1, 1'b1);
      nominal_bit("rnd");
      switch_sequence();
      nominal_bit("rnd after");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule